// File: doc/BRIEF.md
# GPIO Function-Select Crossbar

This block sits between the user I/O pads and the on-chip peripherals. Each pad has a small select register holding a function code. That code decides which peripheral's output value and output enable reach the pad. The pad's input value is routed back to the peripheral input that the chosen function maps to that pad.

The peripherals on the crossbar are:
- two SPI ports, two UARTs and two I2C ports;
- eight PWM slices, each with two channels;
- a software-driven I/O port;
- two programmable-I/O blocks;
- the clock generator's external inputs and outputs;
- the USB power-detect signals.

Each peripheral's role on a pad follows a fixed arithmetic pattern of the pad number. The select registers are loaded through a one-cycle write port. Everything after the registers is combinational.

Two input rules matter to software:
- When several pads select the same peripheral input, that input sees the OR of those pads.
- The software I/O port and both programmable-I/O blocks always see every pad's input, whatever code is selected.

Top module: `gpio_xbar`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every select register holds the null code 31. Every pad output enable and pad output is then 0.
- R2: A write with `wr_en` high loads `wr_data` into the select register of pad `wr_addr` at the next rising clock edge. All other pads keep their codes. Writes to addresses at or above the pad count change nothing.
- R3: With mixed selections across pads, each pad's `pad_out`/`pad_oe` come only from its selected function.
- R4: Code 5 (software I/O) drives pad n from `sio_out[n]`/`sio_oe[n]`. The port drives no pad under any other code. `sio_in` always equals `pad_in`.
- R5: Code 6 drives pad n from `pio0_out[n]`/`pio0_oe[n]`, and code 7 drives it from `pio1_out[n]`/`pio1_oe[n]`. `pio_in` always equals `pad_in`.
- R6: Code 1 (SPI) uses slot k = ((n>>3)&1)*4 + n%4. The role order within a port is RX, CSn, SCK, TX. Pad n drives `spi_out[k]`/`spi_oe[k]` and feeds `spi_in[k]`.
- R7: Code 2 (UART) uses slot k = (((n+4)>>3)&1)*4 + n%4. The role order is TX, RX, CTS, RTS. Out, oe and in use the same slot.
- R8: Code 3 (I2C) uses slot k = ((n>>1)&1)*2 + n%2, where even pads carry data and odd pads carry clock.
- R9: Code 4 (PWM) uses slot k = ((n>>1)%8)*2 + n%2, so even pads carry channel A and odd pads carry channel B. An odd pad also feeds `pwm_b_in[(n>>1)%8]`.
- R10: Code 8 (clock) is valid only on pads 20–25.
  - Pads 21, 23, 24 and 25 drive `clk_gpout[0..3]` with output enable 1.
  - Pads 20 and 22 feed `clk_gpin[0]` and `clk_gpin[1]` with output enable 0.
- R11: Code 9 (USB) depends on n%3.
  - n%3=1 feeds `usb_vbus_det`.
  - n%3=2 drives `usb_vbus_en` with output enable 1.
  - n%3=0 feeds `usb_ovcur_det`.
- R12: A peripheral input selected on several pads receives the OR of those pads' inputs. A peripheral input selected on no pad reads 0.
- R13: Codes 0 and 10–31, and code 8 on a pad outside 20–25, give `pad_out`=0 and `pad_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Select write strobe |
| wr_addr | input | 5 | Pad number to write |
| wr_data | input | 5 | Function code to load |
| pad_in | input | 30 | Pad input values |
| pad_out | output | 30 | Pad output values |
| pad_oe | output | 30 | Pad output enables |
| spi_out | input | 8 | SPI slot outputs (port*4+role) |
| spi_oe | input | 8 | SPI slot output enables |
| spi_in | output | 8 | SPI slot inputs |
| uart_out | input | 8 | UART slot outputs |
| uart_oe | input | 8 | UART slot output enables |
| uart_in | output | 8 | UART slot inputs |
| i2c_out | input | 4 | I2C slot outputs |
| i2c_oe | input | 4 | I2C slot output enables |
| i2c_in | output | 4 | I2C slot inputs |
| pwm_out | input | 16 | PWM channel outputs (slice*2+channel) |
| pwm_oe | input | 16 | PWM channel output enables |
| pwm_b_in | output | 8 | PWM channel-B measurement inputs |
| sio_out | input | 30 | Software I/O output per pad |
| sio_oe | input | 30 | Software I/O output enable per pad |
| sio_in | output | 30 | Software I/O view of all pads |
| pio0_out | input | 30 | Programmable-I/O block 0 outputs |
| pio0_oe | input | 30 | Programmable-I/O block 0 output enables |
| pio1_out | input | 30 | Programmable-I/O block 1 outputs |
| pio1_oe | input | 30 | Programmable-I/O block 1 output enables |
| pio_in | output | 30 | Programmable-I/O view of all pads |
| clk_gpout | input | 4 | Clock generator outputs |
| clk_gpin | output | 2 | Clock generator external inputs |
| usb_vbus_en | input | 1 | USB VBUS enable drive |
| usb_vbus_det | output | 1 | USB VBUS detect |
| usb_ovcur_det | output | 1 | USB overcurrent detect |

## Verification
On every cycle, the assertions check four things:
- a write lands in exactly the addressed select register, and no other register moves;
- a pad is never enabled under an invalid or null code;
- an enabled pad under codes 5, 6 or 7 always reflects an enabled software or programmable-I/O source;
- all-zero pad inputs never produce a high peripheral input.

The exact slot arithmetic for every pad and code, the OR merging of shared inputs and the out-of-range write addresses can only be shown by the bench. It sweeps all 32 codes over all pads, then runs mixed per-pad selections.

// File: rtl/gpio_xbar_pkg.sv
`timescale 1ns/1ps
package gpio_xbar_pkg;

  localparam int FW = 5;

  localparam logic [FW-1:0] FN_SPI  = 5'd1;
  localparam logic [FW-1:0] FN_UART = 5'd2;
  localparam logic [FW-1:0] FN_I2C  = 5'd3;
  localparam logic [FW-1:0] FN_PWM  = 5'd4;
  localparam logic [FW-1:0] FN_SIO  = 5'd5;
  localparam logic [FW-1:0] FN_PIO0 = 5'd6;
  localparam logic [FW-1:0] FN_PIO1 = 5'd7;
  localparam logic [FW-1:0] FN_CLK  = 5'd8;
  localparam logic [FW-1:0] FN_USB  = 5'd9;
  localparam logic [FW-1:0] FN_NULL = 5'd31;

  localparam int SPI_PORTS   = 2;
  localparam int SPI_ROLES   = 4;
  localparam int SPI_SLOTS   = SPI_PORTS * SPI_ROLES;
  localparam int UART_PORTS  = 2;
  localparam int UART_ROLES  = 4;
  localparam int UART_SLOTS  = UART_PORTS * UART_ROLES;
  localparam int I2C_PORTS   = 2;
  localparam int I2C_ROLES   = 2;
  localparam int I2C_SLOTS   = I2C_PORTS * I2C_ROLES;
  localparam int PWM_SLICES  = 8;
  localparam int PWM_CHANS   = 2;
  localparam int PWM_SLOTS   = PWM_SLICES * PWM_CHANS;
  localparam int CLK_IN_N    = 2;
  localparam int CLK_OUT_N   = 4;
  localparam int USB_KINDS   = 3;

  localparam int SPI_KW  = $clog2(SPI_SLOTS);
  localparam int UART_KW = $clog2(UART_SLOTS);
  localparam int I2C_KW  = $clog2(I2C_SLOTS);
  localparam int PWM_KW  = $clog2(PWM_SLOTS);
  localparam int SLC_KW  = $clog2(PWM_SLICES);
  localparam int CLKO_KW = $clog2(CLK_OUT_N);
  localparam int CLKI_KW = $clog2(CLK_IN_N);

  // Role/slot arithmetic shared by the output mux and the input merge.
  function automatic logic [SPI_KW-1:0] spi_slot(int n);
    return SPI_KW'(((n >> 3) & 1) * SPI_ROLES + (n % SPI_ROLES));
  endfunction

  function automatic logic [UART_KW-1:0] uart_slot(int n);
    return UART_KW'((((n + 4) >> 3) & 1) * UART_ROLES + (n % UART_ROLES));
  endfunction

  function automatic logic [I2C_KW-1:0] i2c_slot(int n);
    return I2C_KW'(((n >> 1) & 1) * I2C_ROLES + (n % I2C_ROLES));
  endfunction

  function automatic logic [PWM_KW-1:0] pwm_slot(int n);
    return PWM_KW'(((n >> 1) % PWM_SLICES) * PWM_CHANS + (n % PWM_CHANS));
  endfunction

  function automatic logic [SLC_KW-1:0] pwm_slice(int n);
    return SLC_KW'((n >> 1) % PWM_SLICES);
  endfunction

  function automatic logic clk_is_out(int n);
    return (n == 21) || (n == 23) || (n == 24) || (n == 25);
  endfunction

  function automatic logic clk_is_in(int n);
    return (n == 20) || (n == 22);
  endfunction

  function automatic logic [CLKO_KW-1:0] clk_out_idx(int n);
    return (n >= 23 && n <= 25) ? CLKO_KW'(n - 22) : '0;
  endfunction

  function automatic logic [CLKI_KW-1:0] clk_in_idx(int n);
    return CLKI_KW'(n == 22);
  endfunction

  function automatic logic fn_valid(logic [FW-1:0] code, int n);
    case (code)
      FN_SPI, FN_UART, FN_I2C, FN_PWM, FN_SIO, FN_PIO0, FN_PIO1, FN_USB: return 1'b1;
      FN_CLK:  return (n >= 20) && (n <= 25);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sel_bank.sv
`timescale 1ns/1ps
module gpio_sel_bank
  import gpio_xbar_pkg::*;
#(
  parameter int NPADS = 30,
  localparam int AW = $clog2(NPADS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [FW-1:0] wr_data,
  output logic [FW-1:0] sel_q [NPADS]
);

  logic [NPADS-1:0] sel_we;
  logic [FW-1:0]    sel_d [NPADS];

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    // per-pad clock enable; addresses >= NPADS decode to no pad
    always_comb begin
      sel_we[p] = wr_en && (wr_addr == AW'(p));
      sel_d[p]  = sel_we[p] ? wr_data : sel_q[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sel_q[p] <= FN_NULL;
      else if (sel_we[p]) sel_q[p] <= sel_d[p];
    end

    // R2: an addressed write lands on the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_addr) == p)) |=> (sel_q[p] == $past(wr_data)));

    // R2: no write to this pad leaves its code untouched
    a_r2_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || (int'(wr_addr) != p)) |=> $stable(sel_q[p]));
  end

endmodule

// File: rtl/gpio_pad_mux.sv
`timescale 1ns/1ps
module gpio_pad_mux
  import gpio_xbar_pkg::*;
#(
  parameter int PAD = 0
) (
  input  logic [FW-1:0] sel,
  input  logic          spi_o,
  input  logic          spi_e,
  input  logic          uart_o,
  input  logic          uart_e,
  input  logic          i2c_o,
  input  logic          i2c_e,
  input  logic          pwm_o,
  input  logic          pwm_e,
  input  logic          sio_o,
  input  logic          sio_e,
  input  logic          pio0_o,
  input  logic          pio0_e,
  input  logic          pio1_o,
  input  logic          pio1_e,
  input  logic          clk_o,
  input  logic          usb_o,
  output logic          pad_out,
  output logic          pad_oe
);

  localparam logic IS_CLK_OUT = clk_is_out(PAD);
  localparam logic IS_USB_EN  = (PAD % USB_KINDS) == 2;

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    case (sel)
      FN_SPI:  begin pad_out = spi_o;  pad_oe = spi_e;  end
      FN_UART: begin pad_out = uart_o; pad_oe = uart_e; end
      FN_I2C:  begin pad_out = i2c_o;  pad_oe = i2c_e;  end
      FN_PWM:  begin pad_out = pwm_o;  pad_oe = pwm_e;  end
      FN_SIO:  begin pad_out = sio_o;  pad_oe = sio_e;  end
      FN_PIO0: begin pad_out = pio0_o; pad_oe = pio0_e; end
      FN_PIO1: begin pad_out = pio1_o; pad_oe = pio1_e; end
      FN_CLK: begin
        if (IS_CLK_OUT) begin
          pad_out = clk_o;
          pad_oe  = 1'b1;
        end
      end
      FN_USB: begin
        if (IS_USB_EN) begin
          pad_out = usb_o;
          pad_oe  = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/gpio_in_merge.sv
`timescale 1ns/1ps
module gpio_in_merge
  import gpio_xbar_pkg::*;
#(
  parameter int NPADS = 30
) (
  input  logic [FW-1:0]         sel [NPADS],
  input  logic [NPADS-1:0]      pad_in,
  output logic [SPI_SLOTS-1:0]  spi_in,
  output logic [UART_SLOTS-1:0] uart_in,
  output logic [I2C_SLOTS-1:0]  i2c_in,
  output logic [PWM_SLICES-1:0] pwm_b_in,
  output logic [CLK_IN_N-1:0]   clk_gpin,
  output logic                  usb_vbus_det,
  output logic                  usb_ovcur_det
);

  // OR network: every pad selecting a peripheral input contributes to it
  always_comb begin
    spi_in        = '0;
    uart_in       = '0;
    i2c_in        = '0;
    pwm_b_in      = '0;
    clk_gpin      = '0;
    usb_vbus_det  = 1'b0;
    usb_ovcur_det = 1'b0;
    for (int p = 0; p < NPADS; p++) begin
      case (sel[p])
        FN_SPI:  spi_in[spi_slot(p)]   = spi_in[spi_slot(p)]   | pad_in[p];
        FN_UART: uart_in[uart_slot(p)] = uart_in[uart_slot(p)] | pad_in[p];
        FN_I2C:  i2c_in[i2c_slot(p)]   = i2c_in[i2c_slot(p)]   | pad_in[p];
        FN_PWM: begin
          if ((p % PWM_CHANS) == 1)
            pwm_b_in[pwm_slice(p)] = pwm_b_in[pwm_slice(p)] | pad_in[p];
        end
        FN_CLK: begin
          if (clk_is_in(p))
            clk_gpin[clk_in_idx(p)] = clk_gpin[clk_in_idx(p)] | pad_in[p];
        end
        FN_USB: begin
          if ((p % USB_KINDS) == 1)      usb_vbus_det  = usb_vbus_det  | pad_in[p];
          else if ((p % USB_KINDS) == 0) usb_ovcur_det = usb_ovcur_det | pad_in[p];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_xbar.sv
`timescale 1ns/1ps
module gpio_xbar
  import gpio_xbar_pkg::*;
#(
  parameter int NPADS = 30,
  localparam int AW = $clog2(NPADS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [FW-1:0]         wr_data,
  input  logic [NPADS-1:0]      pad_in,
  output logic [NPADS-1:0]      pad_out,
  output logic [NPADS-1:0]      pad_oe,
  input  logic [SPI_SLOTS-1:0]  spi_out,
  input  logic [SPI_SLOTS-1:0]  spi_oe,
  output logic [SPI_SLOTS-1:0]  spi_in,
  input  logic [UART_SLOTS-1:0] uart_out,
  input  logic [UART_SLOTS-1:0] uart_oe,
  output logic [UART_SLOTS-1:0] uart_in,
  input  logic [I2C_SLOTS-1:0]  i2c_out,
  input  logic [I2C_SLOTS-1:0]  i2c_oe,
  output logic [I2C_SLOTS-1:0]  i2c_in,
  input  logic [PWM_SLOTS-1:0]  pwm_out,
  input  logic [PWM_SLOTS-1:0]  pwm_oe,
  output logic [PWM_SLICES-1:0] pwm_b_in,
  input  logic [NPADS-1:0]      sio_out,
  input  logic [NPADS-1:0]      sio_oe,
  output logic [NPADS-1:0]      sio_in,
  input  logic [NPADS-1:0]      pio0_out,
  input  logic [NPADS-1:0]      pio0_oe,
  input  logic [NPADS-1:0]      pio1_out,
  input  logic [NPADS-1:0]      pio1_oe,
  output logic [NPADS-1:0]      pio_in,
  input  logic [CLK_OUT_N-1:0]  clk_gpout,
  output logic [CLK_IN_N-1:0]   clk_gpin,
  input  logic                  usb_vbus_en,
  output logic                  usb_vbus_det,
  output logic                  usb_ovcur_det
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [FW-1:0] sel_q [NPADS];

  gpio_sel_bank #(.NPADS(NPADS)) u_sel (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sel_q   (sel_q)
  );

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    localparam logic [SPI_KW-1:0]  SPI_K  = spi_slot(p);
    localparam logic [UART_KW-1:0] UART_K = uart_slot(p);
    localparam logic [I2C_KW-1:0]  I2C_K  = i2c_slot(p);
    localparam logic [PWM_KW-1:0]  PWM_K  = pwm_slot(p);
    localparam logic [CLKO_KW-1:0] CLK_K  = clk_out_idx(p);

    gpio_pad_mux #(.PAD(p)) u_mux (
      .sel     (sel_q[p]),
      .spi_o   (spi_out[SPI_K]),
      .spi_e   (spi_oe[SPI_K]),
      .uart_o  (uart_out[UART_K]),
      .uart_e  (uart_oe[UART_K]),
      .i2c_o   (i2c_out[I2C_K]),
      .i2c_e   (i2c_oe[I2C_K]),
      .pwm_o   (pwm_out[PWM_K]),
      .pwm_e   (pwm_oe[PWM_K]),
      .sio_o   (sio_out[p]),
      .sio_e   (sio_oe[p]),
      .pio0_o  (pio0_out[p]),
      .pio0_e  (pio0_oe[p]),
      .pio1_o  (pio1_out[p]),
      .pio1_e  (pio1_oe[p]),
      .clk_o   (clk_gpout[CLK_K]),
      .usb_o   (usb_vbus_en),
      .pad_out (pad_out[p]),
      .pad_oe  (pad_oe[p])
    );

    // R13: a pad is only enabled under a code valid for it
    a_r13_oe_needs_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
      pad_oe[p] |-> fn_valid(sel_q[p], p));

    // R4: software I/O reaches a pad only through its own enable
    a_r4_sio_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pad_oe[p] && (sel_q[p] == FN_SIO)) |-> sio_oe[p]);

    // R5: programmable-I/O blocks drive only through their own enables
    a_r5_pio_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pad_oe[p] && (sel_q[p] == FN_PIO0 || sel_q[p] == FN_PIO1)) |->
      ((sel_q[p] == FN_PIO0) ? pio0_oe[p] : pio1_oe[p]));
  end

  gpio_in_merge #(.NPADS(NPADS)) u_merge (
    .sel           (sel_q),
    .pad_in        (pad_in),
    .spi_in        (spi_in),
    .uart_in       (uart_in),
    .i2c_in        (i2c_in),
    .pwm_b_in      (pwm_b_in),
    .clk_gpin      (clk_gpin),
    .usb_vbus_det  (usb_vbus_det),
    .usb_ovcur_det (usb_ovcur_det)
  );

  // software and programmable I/O observe every pad unconditionally
  assign sio_in = pad_in;
  assign pio_in = pad_in;

  // R12: quiet pads can never raise a peripheral input
  a_r12_quiet_inputs: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pad_in == '0) |-> ((spi_in == '0) && (uart_in == '0) && (i2c_in == '0) &&
                        (pwm_b_in == '0) && (clk_gpin == '0) &&
                        !usb_vbus_det && !usb_ovcur_det));

endmodule

// File: tb/tb_gpio_xbar.sv
`timescale 1ns/1ps
module tb_gpio_xbar;

  localparam int N = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [4:0] wr_addr, wr_data;
  logic [N-1:0] pad_in, pad_out, pad_oe;
  logic [7:0] spi_out, spi_oe, spi_in, uart_out, uart_oe, uart_in;
  logic [3:0] i2c_out, i2c_oe, i2c_in;
  logic [15:0] pwm_out, pwm_oe;
  logic [7:0] pwm_b_in;
  logic [N-1:0] sio_out, sio_oe, sio_in, pio0_out, pio0_oe, pio1_out, pio1_oe, pio_in;
  logic [3:0] clk_gpout;
  logic [1:0] clk_gpin;
  logic usb_vbus_en, usb_vbus_det, usb_ovcur_det;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int sel_m [N];

  always #2.5 clk = ~clk;

  gpio_xbar dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .spi_out(spi_out), .spi_oe(spi_oe), .spi_in(spi_in),
    .uart_out(uart_out), .uart_oe(uart_oe), .uart_in(uart_in),
    .i2c_out(i2c_out), .i2c_oe(i2c_oe), .i2c_in(i2c_in),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .pwm_b_in(pwm_b_in),
    .sio_out(sio_out), .sio_oe(sio_oe), .sio_in(sio_in),
    .pio0_out(pio0_out), .pio0_oe(pio0_oe), .pio1_out(pio1_out), .pio1_oe(pio1_oe),
    .pio_in(pio_in), .clk_gpout(clk_gpout), .clk_gpin(clk_gpin),
    .usb_vbus_en(usb_vbus_en), .usb_vbus_det(usb_vbus_det), .usb_ovcur_det(usb_ovcur_det)
  );

  task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(int c);
    case (c)
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      5: return "R4";
      6: return "R5";
      7: return "R5";
      8: return "R10";
      9: return "R11";
      default: return "R13";
    endcase
  endfunction

  // expected outputs derived from the requirement formulas
  task automatic check_all(string req);
    logic [N-1:0] e_out = '0, e_oe = '0;
    logic [7:0] e_spi = '0, e_uart = '0, e_pwmb = '0;
    logic [3:0] e_i2c = '0;
    logic [1:0] e_clk = '0;
    logic e_vd = 0, e_oc = 0;
    for (int p = 0; p < N; p++) begin
      int k;
      case (sel_m[p])
        1: begin k = ((p >> 3) & 1) * 4 + p % 4;
             e_out[p] = spi_out[k]; e_oe[p] = spi_oe[k]; e_spi[k] |= pad_in[p]; end
        2: begin k = (((p + 4) >> 3) & 1) * 4 + p % 4;
             e_out[p] = uart_out[k]; e_oe[p] = uart_oe[k]; e_uart[k] |= pad_in[p]; end
        3: begin k = ((p >> 1) & 1) * 2 + p % 2;
             e_out[p] = i2c_out[k]; e_oe[p] = i2c_oe[k]; e_i2c[k] |= pad_in[p]; end
        4: begin k = ((p >> 1) % 8) * 2 + p % 2;
             e_out[p] = pwm_out[k]; e_oe[p] = pwm_oe[k];
             if (p % 2 == 1) e_pwmb[(p >> 1) % 8] |= pad_in[p]; end
        5: begin e_out[p] = sio_out[p];  e_oe[p] = sio_oe[p];  end
        6: begin e_out[p] = pio0_out[p]; e_oe[p] = pio0_oe[p]; end
        7: begin e_out[p] = pio1_out[p]; e_oe[p] = pio1_oe[p]; end
        8: begin
             if (p == 20) e_clk[0] |= pad_in[p];
             else if (p == 22) e_clk[1] |= pad_in[p];
             else if (p == 21) begin e_out[p] = clk_gpout[0]; e_oe[p] = 1; end
             else if (p >= 23 && p <= 25) begin e_out[p] = clk_gpout[p-22]; e_oe[p] = 1; end
           end
        9: begin
             if (p % 3 == 1) e_vd |= pad_in[p];
             else if (p % 3 == 0) e_oc |= pad_in[p];
             else begin e_out[p] = usb_vbus_en; e_oe[p] = 1; end
           end
        default: ;
      endcase
    end
    cmp(req, "pad_out", 64'(pad_out), 64'(e_out));
    cmp(req, "pad_oe", 64'(pad_oe), 64'(e_oe));
    cmp(req, "spi_in", 64'(spi_in), 64'(e_spi));
    cmp(req, "uart_in", 64'(uart_in), 64'(e_uart));
    cmp(req, "i2c_in", 64'(i2c_in), 64'(e_i2c));
    cmp(req, "pwm_b_in", 64'(pwm_b_in), 64'(e_pwmb));
    cmp(req, "clk_gpin", 64'(clk_gpin), 64'(e_clk));
    cmp(req, "usb_in", 64'({usb_vbus_det, usb_ovcur_det}), 64'({e_vd, e_oc}));
    cmp("R4", "sio_in", 64'(sio_in), 64'(pad_in));
    cmp("R5", "pio_in", 64'(pio_in), 64'(pad_in));
  endtask

  task automatic stim();
    @(negedge clk);
    pad_in = N'($urandom); spi_out = 8'($urandom); spi_oe = 8'($urandom);
    uart_out = 8'($urandom); uart_oe = 8'($urandom);
    i2c_out = 4'($urandom); i2c_oe = 4'($urandom);
    pwm_out = 16'($urandom); pwm_oe = 16'($urandom);
    sio_out = N'($urandom); sio_oe = N'($urandom);
    pio0_out = N'($urandom); pio0_oe = N'($urandom);
    pio1_out = N'($urandom); pio1_oe = N'($urandom);
    clk_gpout = 4'($urandom); usb_vbus_en = 1'($urandom);
    #1;
  endtask

  task automatic write_sel(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 5'(a); wr_data = 5'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    void'($urandom(7));
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    for (int p = 0; p < N; p++) sel_m[p] = 31;
    stim();
    check_all("R1");                       // R1: inside reset
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    stim();
    check_all("R1");                       // R1: after release, before writes

    // every code on every pad
    for (int c = 0; c < 32; c++) begin
      for (int p = 0; p < N; p++) begin write_sel(p, c); sel_m[p] = c; end
      for (int r = 0; r < 4; r++) begin stim(); check_all(tag_of(c)); end
    end

    // R12: OR merge of shared SPI inputs (pads 0 and 16 share slot 0)
    for (int p = 0; p < N; p++) begin write_sel(p, 1); sel_m[p] = 1; end
    stim(); pad_in = '0; pad_in[16] = 1'b1; #1;
    check_all("R12");
    cmp("R12", "spi_in[0] from pad16", 64'(spi_in[0]), 64'(1));
    pad_in = '0; pad_in[0] = 1'b1; pad_in[16] = 1'b1; #1;
    check_all("R12");
    pad_in = '0; #1;
    check_all("R12");
    for (int p = 0; p < N; p++) begin write_sel(p, 31); sel_m[p] = 31; end
    stim();
    check_all("R12");                      // no pad selected: every input 0

    // R2: out-of-range addresses ignored; single write touches one pad
    for (int p = 0; p < N; p++) begin write_sel(p, 2); sel_m[p] = 2; end
    write_sel(30, 5); write_sel(31, 5);
    stim(); check_all("R2");
    write_sel(7, 5); sel_m[7] = 5;
    stim(); check_all("R2");

    // R3: mixed per-pad selections
    for (int r = 0; r < 20; r++) begin
      for (int p = 0; p < N; p++) begin
        int c = int'($urandom % 11);
        if (c == 10) c = 31;
        write_sel(p, c); sel_m[p] = c;
      end
      for (int k = 0; k < 3; k++) begin stim(); check_all("R3"); end
    end

    // R1: reset in mid-run returns every pad to null
    @(negedge clk); rst_n = 0;
    for (int p = 0; p < N; p++) sel_m[p] = 31;
    #1; check_all("R1");
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    stim(); check_all("R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule